// File: doc/BRIEF.md
# Change-of-State Interrupt Controller

The block watches forty-eight asynchronous input lines, organised as six 8-bit ports in two groups of three. It raises one latched interrupt request as soon as any bit of an enabled port toggles. Every input bit is brought into the clock domain through a two-flop synchronizer. Each port compares its synchronized value with the value it held on the previous cycle. A port that differs, and that is neither masked off nor configured as an output, records a change event.

Events collect in a sticky six-bit status vector. The interrupt line is high exactly while that vector is non-zero. The host programs an active-low enable mask with a write to one address. It drops the request with a write of any data to a second address. A change that arrives in the same cycle as that clear write is not lost: it sets its status bit again. Rewriting the mask never removes a request that is already latched.

Top module: `cos_irq_ctrl`

## Requirements
- R1: After reset the mask, the status vector and the interrupt output are all zero, so every port starts out enabled.
- R2: A write with `wr_addr` = 0xB loads `wr_data[5:0]` into the mask, visible on `mask_o` one cycle later. Bit p of the mask, of `status_o` and of `port_is_out` refers to port p, which occupies `port_in[8p+7:8p]`. Ports 0, 1 and 2 are ports A, B and C of group 0, and ports 3, 4 and 5 are ports A, B and C of group 1.
- R3: A toggle of any bit of an enabled port, with its mask bit 0, sets `status_o[p]` and `irq_o`. The toggle is applied between clock edges. The outputs show the new state after the third rising edge that follows it, and not after the second.
- R4: A port whose mask bit is 1 may toggle without changing `status_o` or `irq_o`.
- R5: Status bits and `irq_o` stay set until a write to `wr_addr` = 0xF, whatever its data. That write clears them on the next edge.
- R6: A change event detected in the same cycle as a clear write leaves its status bit and `irq_o` set after the clear.
- R7: Writing the mask, including a write that masks a port already flagged, does not clear any status bit or `irq_o`.
- R8: While `port_is_out[p]` is 1, toggles on port p are ignored.
- R9: Writes to any address other than 0xB and 0xF change neither the mask nor the status.
- R10: `irq_o` is 1 exactly when `status_o` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_in | input | 48 | Six 8-bit asynchronous input ports |
| port_is_out | input | 6 | Per-port flag: port drives outputs, ignore its toggles |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 4 | Host write address |
| wr_data | input | 8 | Host write data |
| irq_o | output | 1 | Latched interrupt request |
| status_o | output | 6 | Ports changed since the last clear |
| mask_o | output | 6 | Current mask (1 = port disabled) |

## Verification
The bench builds the block with its default parameters: two groups of three 8-bit ports, two synchronizer stages and output-port gating enabled. With these values all six mask positions, the group boundary between bit 2 and bit 3, and the direction gate are exercised. The three-edge latency can be counted exactly at the outputs. Random rounds combine mask values, direction flags, multi-port toggles and occasional clears. Directed cases place a toggle on the exact cycle of a clear write and mask a port after it has already been flagged.

// File: rtl/cos_pkg.sv
package cos_pkg;

    localparam int unsigned DEF_GROUPS     = 2;
    localparam int unsigned DEF_PORTS_GRP  = 3;
    localparam int unsigned DEF_PORT_W     = 8;
    localparam int unsigned DEF_SYNC_DEPTH = 2;
    localparam int unsigned DEF_ADDR_W     = 4;
    localparam int unsigned DEF_DATA_W     = 8;

    // Host write classification
    typedef enum logic [1:0] {
        WR_NONE  = 2'd0,
        WR_MASK  = 2'd1,
        WR_CLEAR = 2'd2
    } wr_kind_e;

endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
    parameter int unsigned W      = 48,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < int'(STAGES); s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/cos_port_detect.sv
module cos_port_detect #(
    parameter int unsigned W         = 8,
    parameter bit          GATE_OUTS = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_i,
    input  logic         disabled_i,
    input  logic         is_out_i,
    output logic         event_o
);

    logic [W-1:0] prev_d, prev_q;
    logic         differs;
    logic         blocked;

    always_comb begin
        prev_d  = sync_i;
        differs = |(sync_i ^ prev_q);
        if (GATE_OUTS) begin
            blocked = disabled_i | is_out_i;
        end else begin
            blocked = disabled_i;
        end
        event_o = differs & ~blocked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    // R3
    steady_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(sync_i) |=> !event_o || !$stable(sync_i));

endmodule

// File: rtl/cos_host_decode.sv
module cos_host_decode
    import cos_pkg::*;
#(
    parameter int unsigned ADDR_W     = 4,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned NP         = 6,
    parameter logic [ADDR_W-1:0] MASK_ADDR  = 'hB,
    parameter logic [ADDR_W-1:0] CLEAR_ADDR = 'hF
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output wr_kind_e          kind_o,
    output logic [NP-1:0]     mask_wdata_o
);

    always_comb begin
        kind_o       = WR_NONE;
        mask_wdata_o = wr_data[NP-1:0];
        if (wr_en) begin
            if (wr_addr == MASK_ADDR) begin
                kind_o = WR_MASK;
            end else if (wr_addr == CLEAR_ADDR) begin
                kind_o = WR_CLEAR;
            end
        end
    end

endmodule

// File: rtl/cos_irq_ctrl.sv
module cos_irq_ctrl
    import cos_pkg::*;
#(
    parameter int unsigned GROUPS     = DEF_GROUPS,
    parameter int unsigned PORTS_GRP  = DEF_PORTS_GRP,
    parameter int unsigned PORT_W     = DEF_PORT_W,
    parameter int unsigned SYNC_DEPTH = DEF_SYNC_DEPTH,
    parameter int unsigned ADDR_W     = DEF_ADDR_W,
    parameter int unsigned DATA_W     = DEF_DATA_W,
    parameter bit          GATE_OUTS  = 1'b1,
    localparam int unsigned NP        = GROUPS * PORTS_GRP,
    localparam int unsigned TOTAL_W   = NP * PORT_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TOTAL_W-1:0] port_in,
    input  logic [NP-1:0]      port_is_out,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0]  wr_data,
    output logic               irq_o,
    output logic [NP-1:0]      status_o,
    output logic [NP-1:0]      mask_o
);

    typedef struct packed {
        logic [NP-1:0] mask;
        logic [NP-1:0] status;
        logic          irq;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;

    logic [TOTAL_W-1:0] sync_bus;
    logic [NP-1:0]      evt;
    wr_kind_e           kind;
    logic [NP-1:0]      mask_wdata;

    cos_sync #(
        .W      (TOTAL_W),
        .STAGES (SYNC_DEPTH)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (port_in),
        .sync_o  (sync_bus)
    );

    for (genvar p = 0; p < int'(NP); p++) begin : g_port
        cos_port_detect #(
            .W         (PORT_W),
            .GATE_OUTS (GATE_OUTS)
        ) u_det (
            .clk        (clk),
            .rst_n      (rst_n),
            .sync_i     (sync_bus[p*PORT_W +: PORT_W]),
            .disabled_i (st_q.mask[p]),
            .is_out_i   (port_is_out[p]),
            .event_o    (evt[p])
        );
    end

    cos_host_decode #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .NP     (NP)
    ) u_dec (
        .wr_en        (wr_en),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .kind_o       (kind),
        .mask_wdata_o (mask_wdata)
    );

    always_comb begin
        st_d = st_q;
        if (kind == WR_MASK) begin
            st_d.mask = mask_wdata;
        end
        if (kind == WR_CLEAR) begin
            st_d.status = '0;
        end
        st_d.status = st_d.status | evt;
        st_d.irq    = |st_d.status;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_o    = st_q.irq;
    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;

    // R2
    mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WR_MASK) |=> (st_q.mask == $past(wr_data[NP-1:0])));

    // R4
    masked_port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((st_q.status & ~$past(st_q.status) & $past(st_q.mask)) == '0));

    // R5
    status_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != WR_CLEAR) |=> ((st_q.status & $past(st_q.status)) == $past(st_q.status)));

    // R5
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WR_CLEAR && evt == '0) |=> (st_q.status == '0 && !st_q.irq));

    // R7
    mask_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WR_MASK && evt == '0) |=> (st_q.status == $past(st_q.status)));

    // R6
    clear_race_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == WR_CLEAR && evt != '0) |=> st_q.irq);

endmodule

// File: tb/tb_cos_irq_ctrl.sv
module tb_cos_irq_ctrl;

    localparam int NP = 6;
    localparam int PW = 8;
    localparam int TW = NP * PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] port_in = '0;
    logic [NP-1:0] port_is_out = '0;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [7:0]    wr_data = '0;
    logic          irq_o;
    logic [NP-1:0] status_o;
    logic [NP-1:0] mask_o;

    int tests = 0;
    int fails = 0;
    logic done = 1'b0;

    logic [NP-1:0] exp_status = '0;
    logic [NP-1:0] exp_mask   = '0;

    always #2 clk = ~clk;

    cos_irq_ctrl dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_in     (port_in),
        .port_is_out (port_is_out),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .irq_o       (irq_o),
        .status_o    (status_o),
        .mask_o      (mask_o)
    );

    function automatic logic [NP-1:0] port_events(input logic [TW-1:0] a, input logic [TW-1:0] b,
                                                   input logic [NP-1:0] m, input logic [NP-1:0] d);
        logic [NP-1:0] r;
        for (int p = 0; p < NP; p++) begin
            r[p] = (a[p*PW +: PW] != b[p*PW +: PW]) && !m[p] && !d[p];
        end
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_outputs(input string req);
        chk({req, " status"}, 32'(status_o), 32'(exp_status));
        chk({req, " irq"}, 32'(irq_o), 32'(exp_status != '0));
        chk({req, " mask"}, 32'(mask_o), 32'(exp_mask));
    endtask

    task automatic host_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 4'hB) exp_mask = d[NP-1:0];
        if (a == 4'hF) exp_status = '0;
    endtask

    task automatic apply_in(input logic [TW-1:0] v);
        @(negedge clk);
        exp_status = exp_status | port_events(port_in, v, exp_mask, port_is_out);
        port_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] v;
        void'($urandom(32'h5eed_c05));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_outputs("R1");

        // R3 latency: toggle port 1 bit 3, not visible after 2 edges, visible after 3
        @(negedge clk);
        port_in[1*PW + 3] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R3 early", 32'(status_o), 32'h0);
        @(posedge clk); @(negedge clk);
        chk("R3 latched", 32'(status_o), 32'h02);
        chk("R10 irq", 32'(irq_o), 32'h1);
        exp_status = 6'h02;

        // R5 sticky, then clear with arbitrary data
        repeat (5) @(negedge clk);
        chk_outputs("R5 hold");
        host_write(4'hF, 8'h5A);
        chk_outputs("R5 clear");

        // R2 mask write and bit mapping: mask all but group1 port C (bit 5)
        host_write(4'hB, 8'h1F);
        chk_outputs("R2 mask");
        v = port_in; v[0 +: 40] = ~v[0 +: 40];
        apply_in(v);
        chk_outputs("R4 masked ports quiet");
        v = port_in; v[5*PW] = ~v[5*PW];
        apply_in(v);
        chk_outputs("R2 bit5 port5");

        // R7 masking a flagged port keeps status
        host_write(4'hB, 8'h3F);
        chk_outputs("R7 mask after flag");

        // R9 other addresses ignored
        host_write(4'h3, 8'h00);
        host_write(4'hA, 8'h00);
        chk_outputs("R9 stray write");

        // R8 direction gating
        host_write(4'hF, 8'h00);
        host_write(4'hB, 8'h00);
        @(negedge clk);
        port_is_out = 6'h09;
        v = ~port_in;
        apply_in(v);
        chk_outputs("R8 outputs ignored");
        port_is_out = '0;
        host_write(4'hF, 8'h00);
        chk_outputs("R8 cleared");

        // R6 change in same cycle as clear; port 2 already flagged
        v = port_in; v[2*PW] = ~v[2*PW];
        apply_in(v);
        @(negedge clk);
        port_in[4*PW + 7] = ~port_in[4*PW + 7];
        @(posedge clk); @(posedge clk); @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'hF; wr_data = 8'hFF;
        @(negedge clk);
        wr_en = 1'b0;
        exp_status = 6'h10;
        chk_outputs("R6 clear race");
        host_write(4'hF, 8'h00);

        // Random rounds (R3 R4 R5 R8 R10)
        for (int i = 0; i < 150; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[3:0] == 0) host_write(4'hF, 8'($urandom));
            if (r[5:4] == 0) host_write(4'hB, 8'($urandom));
            @(negedge clk);
            port_is_out = (r[7:6] == 0) ? 6'($urandom) : '0;
            repeat (2) @(negedge clk);
            v = port_in;
            for (int p = 0; p < NP; p++) begin
                if ($urandom_range(0, 2) == 0) v[p*PW +: PW] = 8'($urandom);
            end
            apply_in(v);
            chk_outputs("R3 random");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule